// File: doc/BRIEF.md
# Block Protection State Machine

This block keeps the write-protection state of a small set of flash memory blocks. The count is set by a parameter. Each block has three flip-flops: a protect bit, a lock bit, and a saved copy of the protect bit. A command strobe carries a block index and an operation. The operation can set protection, clear protection or lock the block. A write-protect pin, sampled on the clock, decides how strong a lock is.

While the pin is high, a locked block can still be unprotected. While the pin is low, a locked block is forced to protected and ignores unprotect. When the pin goes high again, the block gets back the protect value it had just before the pin fell.

For every block the block gives one program/erase permission bit. It also gives a 16-bit status word for one queried block. A program/erase engine uses the permission bits. A signature-read path returns the status word.

Top module: `blkprot_ctrl`

## Requirements
- R1: `qry_word` is combinational on the stored state of the block selected by `qry_idx`. Bit 0 is the protect bit and bit 1 is the lock bit, so the word is 0x0001 for protected and unlocked, 0x0000 for unprotected and unlocked, 0x0003 for protected and locked, and 0x0002 for unprotected and locked. Bits 15..2 are always zero. A query index of NBLK or above returns 0x0000.
- R2: While `rst_n` is low, and after it is released, every block is protected and unlocked (status 0x0001). This holds whatever level `wp_pin` has.
- R3: `pe_allow[i]` is 1 exactly when block i's protect bit is 0.
- R4: A command with `cmd_op` = 1 (protect) sets the protect bit of the indexed block. With the pin low and the block locked, the block stays protected and locked.
- R5: A command with `cmd_op` = 2 (unprotect) clears the protect bit, unless the pin is low and the block is locked. In that case the block is unchanged.
- R6: A command with `cmd_op` = 3 (lock) leaves the block locked and protected, at either pin level. `cmd_op` = 0 does nothing.
- R7: A falling pin edge makes every locked block protected. Unlocked blocks keep their protect bit.
- R8: A rising pin edge returns every locked block to the protect value it held at the last falling edge. A command in the same cycle is applied after this restore.
- R9: Only reset clears a lock bit. No command and no pin activity clears it.
- R10: A command whose index is NBLK or above changes no block's state.
- R11: A command or pin edge present at a clock edge shows in `qry_word` and `pe_allow` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Operation: 0 none, 1 protect, 2 unprotect, 3 lock |
| cmd_idx | input | IDX_W | Target block index |
| wp_pin | input | 1 | Write-protect level, sampled on the clock |
| qry_idx | input | IDX_W | Block whose status is returned |
| qry_word | output | 16 | Status word of the queried block |
| pe_allow | output | NBLK | Program/erase permission, one bit per block |

## Verification
The checker watches these rules on every cycle:
- A lock bit never drops outside reset.
- A falling pin edge leaves every locked block protected.
- A rising pin edge restores the saved value on locked blocks.
- A lock command always lands as locked and protected.
- An unprotect with the pin high always clears the bit.
- Commands to out-of-range indices leave all state frozen.
- Permission bits always agree with the status word.

Some behaviour is a sequence over time, and only the bench scenarios show it:
- The restored value depends on pin history: it comes from a falling edge that happened several commands earlier.
- Reset with the pin held low.
- Unprotect being blocked while a block is locked and the pin is low.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_PROTECT   = 2'd1,
    OP_UNPROTECT = 2'd2,
    OP_LOCK      = 2'd3
  } prot_op_e;

  localparam int STAT_W = 16;

  // Status encoding: bit1 = lock, bit0 = protect, rest zero.
  function automatic logic [STAT_W-1:0] status_code(input logic lk, input logic pr);
    return {{(STAT_W-2){1'b0}}, lk, pr};
  endfunction

  // Next protect value: pin edges first, then a command seen at the new pin level.
  function automatic logic prot_next(
    input logic prot_cur,
    input logic saved,
    input logic lock,
    input logic wp_now,
    input logic fall,
    input logic rise,
    input logic hit_prot,
    input logic hit_unprot,
    input logic hit_lock
  );
    logic p;
    p = prot_cur;
    if (fall && lock)      p = 1'b1;
    else if (rise && lock) p = saved;
    if (hit_lock || hit_prot)                 p = 1'b1;
    else if (hit_unprot && (wp_now || !lock)) p = 1'b0;
    return p;
  endfunction

endpackage

// File: rtl/blkprot_wp_edge.sv
module blkprot_wp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_pin,
  output logic wp_fall,
  output logic wp_rise
);
  logic wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= 1'b1;
    else        wp_q <= wp_pin;
  end

  assign wp_fall = wp_q & ~wp_pin;
  assign wp_rise = ~wp_q & wp_pin;
endmodule

// File: rtl/blkprot_cmd_dec.sv
module blkprot_cmd_dec #(
  parameter int NBLK  = 6,
  parameter int IDX_W = 3
) (
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic [NBLK-1:0]  blk_sel,
  output logic             do_prot,
  output logic             do_unprot,
  output logic             do_lock
);
  import blkprot_pkg::*;

  prot_op_e op;
  assign op = prot_op_e'(cmd_op);

  always_comb begin
    do_prot   = 1'b0;
    do_unprot = 1'b0;
    do_lock   = 1'b0;
    case (op)
      OP_PROTECT:   do_prot   = 1'b1;
      OP_UNPROTECT: do_unprot = 1'b1;
      OP_LOCK:      do_lock   = 1'b1;
      default:      ;
    endcase
  end

  // Indices at or above NBLK match no slot and are dropped.
  for (genvar i = 0; i < NBLK; i++) begin : g_sel
    assign blk_sel[i] = cmd_valid && (cmd_idx == IDX_W'(i));
  end
endmodule

// File: rtl/blkprot_cell.sv
module blkprot_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic do_prot,
  input  logic do_unprot,
  input  logic do_lock,
  input  logic wp_now,
  input  logic wp_fall,
  input  logic wp_rise,
  output logic prot_o,
  output logic lock_o,
  output logic saved_o
);
  import blkprot_pkg::*;

  logic prot_q, lock_q, saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= 1'b1;
      lock_q  <= 1'b0;
      saved_q <= 1'b1;
    end else begin
      if (wp_fall) saved_q <= prot_q;
      prot_q <= prot_next(prot_q, saved_q, lock_q, wp_now, wp_fall, wp_rise,
                          sel && do_prot, sel && do_unprot, sel && do_lock);
      if (sel && do_lock) lock_q <= 1'b1;
    end
  end

  assign prot_o  = prot_q;
  assign lock_o  = lock_q;
  assign saved_o = saved_q;
endmodule

// File: rtl/blkprot_stat_mux.sv
module blkprot_stat_mux #(
  parameter int NBLK  = 6,
  parameter int IDX_W = 3
) (
  input  logic [NBLK-1:0]  lock_vec,
  input  logic [NBLK-1:0]  prot_vec,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [15:0]      qry_word
);
  import blkprot_pkg::*;

  always_comb begin
    qry_word = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (qry_idx == IDX_W'(i)) qry_word = status_code(lock_vec[i], prot_vec[i]);
    end
  end
endmodule

// File: rtl/blkprot_ctrl.sv
module blkprot_ctrl #(
  parameter int NBLK  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             wp_pin,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [15:0]      qry_word,
  output logic [NBLK-1:0]  pe_allow
);
  logic            wp_fall, wp_rise;
  logic [NBLK-1:0] blk_sel;
  logic            do_prot, do_unprot, do_lock;
  logic [NBLK-1:0] prot_vec, lock_vec, saved_vec;

  blkprot_wp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
    .wp_fall(wp_fall), .wp_rise(wp_rise)
  );

  blkprot_cmd_dec #(.NBLK(NBLK), .IDX_W(IDX_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .blk_sel(blk_sel), .do_prot(do_prot), .do_unprot(do_unprot), .do_lock(do_lock)
  );

  for (genvar i = 0; i < NBLK; i++) begin : g_cell
    blkprot_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sel(blk_sel[i]),
      .do_prot(do_prot), .do_unprot(do_unprot), .do_lock(do_lock),
      .wp_now(wp_pin), .wp_fall(wp_fall), .wp_rise(wp_rise),
      .prot_o(prot_vec[i]), .lock_o(lock_vec[i]), .saved_o(saved_vec[i])
    );
  end

  blkprot_stat_mux #(.NBLK(NBLK), .IDX_W(IDX_W)) u_mux (
    .lock_vec(lock_vec), .prot_vec(prot_vec), .qry_idx(qry_idx), .qry_word(qry_word)
  );

  assign pe_allow = ~prot_vec;
endmodule

// File: rtl/blkprot_chk.sv
module blkprot_chk #(
  parameter int NBLK  = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             wp_pin,
  input logic [IDX_W-1:0] qry_idx,
  input logic [15:0]      qry_word,
  input logic [NBLK-1:0]  pe_allow,
  input logic [NBLK-1:0]  prot_vec,
  input logic [NBLK-1:0]  lock_vec,
  input logic [NBLK-1:0]  saved_vec,
  input logic [NBLK-1:0]  blk_sel,
  input logic             wp_fall,
  input logic             wp_rise
);
  // R1
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(qry_word[15:2]) == 0);

  // R10
  oor_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && int'(cmd_idx) >= NBLK && !wp_fall && !wp_rise)
      |=> ($stable(prot_vec) && $stable(lock_vec)));

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[i] |=> lock_vec[i]);

    // R7
    fall_forces_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_fall && lock_vec[i]) |=> prot_vec[i]);

    // R8
    rise_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_rise && lock_vec[i] && !blk_sel[i]) |=> (prot_vec[i] == $past(saved_vec[i])));

    // R6
    lock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd3 && cmd_idx == IDX_W'(i)) |=> (lock_vec[i] && prot_vec[i]));

    // R5
    unprot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2 && cmd_idx == IDX_W'(i) && wp_pin) |=> !prot_vec[i]);

    // R3
    allow_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_idx == IDX_W'(i)) |-> (pe_allow[i] == !qry_word[0]));
  end
endmodule

bind blkprot_ctrl blkprot_chk #(.NBLK(NBLK), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .wp_pin(wp_pin), .qry_idx(qry_idx), .qry_word(qry_word), .pe_allow(pe_allow),
  .prot_vec(prot_vec), .lock_vec(lock_vec), .saved_vec(saved_vec),
  .blk_sel(blk_sel), .wp_fall(wp_fall), .wp_rise(wp_rise)
);

// File: tb/sim_blkprot_ctrl.sv
module sim_blkprot_ctrl;
  localparam int NBLK  = 6;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [IDX_W-1:0] cmd_idx = '0;
  logic             wp_pin = 1'b1;
  logic [IDX_W-1:0] qry_idx = '0;
  logic [15:0]      qry_word;
  logic [NBLK-1:0]  pe_allow;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  blkprot_ctrl #(.NBLK(NBLK), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .wp_pin(wp_pin), .qry_idx(qry_idx), .qry_word(qry_word), .pe_allow(pe_allow)
  );

  // Vector: {wp, valid, op[1:0], idx[2:0], qry[2:0], expected status[3:0]}
  localparam int NV = 22;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,1'b1,2'd2,3'd0,3'd0,4'h0},  // R5 unprotect, pin high
    {1'b1,1'b1,2'd1,3'd0,3'd0,4'h1},  // R4 protect
    {1'b1,1'b1,2'd2,3'd1,3'd1,4'h0},  // R5
    {1'b1,1'b1,2'd3,3'd1,3'd1,4'h3},  // R6 lock, pin high
    {1'b1,1'b1,2'd2,3'd1,3'd1,4'h2},  // R5 locked + pin high: unprotect works
    {1'b0,1'b0,2'd0,3'd0,3'd1,4'h3},  // R7 fall on locked
    {1'b0,1'b1,2'd2,3'd1,3'd1,4'h3},  // R5 blocked
    {1'b0,1'b1,2'd1,3'd1,3'd1,4'h3},  // R4 stays locked/protected
    {1'b1,1'b0,2'd0,3'd0,3'd1,4'h2},  // R8 restore 0
    {1'b1,1'b1,2'd1,3'd1,3'd1,4'h3},  // R4
    {1'b0,1'b0,2'd0,3'd0,3'd1,4'h3},  // R7
    {1'b1,1'b0,2'd0,3'd0,3'd1,4'h3},  // R8 restore 1
    {1'b1,1'b1,2'd2,3'd2,3'd2,4'h0},  // R5
    {1'b0,1'b0,2'd0,3'd0,3'd2,4'h0},  // R7 unlocked block keeps value
    {1'b0,1'b1,2'd2,3'd3,3'd3,4'h0},  // R5 unlocked, pin low
    {1'b0,1'b1,2'd3,3'd3,3'd3,4'h3},  // R6 lock, pin low
    {1'b1,1'b0,2'd0,3'd0,3'd3,4'h3},  // R8 value saved at last fall was 1
    {1'b1,1'b1,2'd2,3'd3,3'd3,4'h2},  // R5
    {1'b1,1'b1,2'd2,3'd6,3'd0,4'h1},  // R10 out-of-range unprotect
    {1'b1,1'b1,2'd3,3'd7,3'd2,4'h0},  // R10 out-of-range lock
    {1'b1,1'b1,2'd1,3'd2,3'd6,4'h0},  // R1 out-of-range query
    {1'b1,1'b0,2'd0,3'd0,3'd2,4'h1}   // R11 previous protect visible
  };
  localparam int VREQ [NV] = '{5,4,5,6,5,7,5,4,8,4,7,8,5,7,5,6,8,5,10,10,1,11};

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic wp, input logic v, input logic [1:0] op,
                       input logic [IDX_W-1:0] idx, input logic [IDX_W-1:0] q);
    @(negedge clk);
    wp_pin = wp; cmd_valid = v; cmd_op = op; cmd_idx = idx; qry_idx = q;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(input logic wp);
    @(negedge clk);
    rst_n = 1'b0; wp_pin = wp; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] snap [NBLK];
    do_reset(1'b1);

    // R2 / R3: every block protected and unlocked after reset
    for (int i = 0; i < NBLK; i++) begin
      qry_idx = IDX_W'(i);
      #1;
      check("R2", "reset status", qry_word, 16'h0001);
    end
    check("R3", "reset permission", 16'(pe_allow), 16'h0000);
    qry_idx = 3'd7;
    #1;
    check("R1", "out-of-range query", qry_word, 16'h0000);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][13], VEC[k][12], VEC[k][11:10], VEC[k][9:7], VEC[k][6:4]);
      check($sformatf("R%0d", VREQ[k]), $sformatf("vector %0d", k), qry_word,
            {12'd0, VEC[k][3:0]});
      if (int'(VEC[k][6:4]) < NBLK)
        check("R3", $sformatf("vector %0d permission", k),
              {15'd0, pe_allow[int'(VEC[k][6:4])]}, {15'd0, ~VEC[k][0]});
    end

    // R10: out-of-range command leaves every block untouched
    for (int i = 0; i < NBLK; i++) begin
      qry_idx = IDX_W'(i); #1; snap[i] = qry_word;
    end
    apply(1'b1, 1'b1, 2'd3, 3'd6, 3'd0);
    apply(1'b1, 1'b1, 2'd2, 3'd7, 3'd0);
    for (int i = 0; i < NBLK; i++) begin
      qry_idx = IDX_W'(i); #1;
      check("R10", $sformatf("block %0d after out-of-range", i), qry_word, snap[i]);
    end

    // R9: lock survives commands and pin toggles (block 1 locked)
    apply(1'b0, 1'b1, 2'd2, 3'd1, 3'd1);
    apply(1'b1, 1'b1, 2'd2, 3'd1, 3'd1);
    check("R9", "lock kept after unprotect", qry_word, 16'h0002);
    apply(1'b0, 1'b0, 2'd0, 3'd0, 3'd1);
    apply(1'b1, 1'b1, 2'd0, 3'd1, 3'd1);
    check("R9", "lock kept after pin toggle", {15'd0, qry_word[1]}, 16'h0001);

    // R2 / R9: reset with pin low clears lock
    do_reset(1'b0);
    for (int i = 0; i < NBLK; i++) begin
      qry_idx = IDX_W'(i); #1;
      check("R2", $sformatf("reset pin low block %0d", i), qry_word, 16'h0001);
    end

    // R5 / R3: unlocked block, pin low, unprotect allowed
    apply(1'b0, 1'b1, 2'd2, 3'd4, 3'd4);
    check("R5", "unprotect unlocked pin low", qry_word, 16'h0000);
    check("R3", "permission block 4", {15'd0, pe_allow[4]}, 16'h0001);

    // R8: rise and unprotect in the same cycle on a locked block
    apply(1'b0, 1'b1, 2'd3, 3'd5, 3'd5);
    apply(1'b1, 1'b1, 2'd2, 3'd5, 3'd5);
    check("R8", "command after restore", qry_word, 16'h0002);

    finish_run();
  end
endmodule